// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor presentation stage of a two-layer interrupt controller. It keeps the processor's current priority, the identifier and priority of the one interrupt on offer to the processor, and a software-written inter-processor request priority. Sources elsewhere offer interrupts one at a time. The block answers each offer in the same cycle with grant or refusal. When a better offer displaces the held one, the displaced identifier is returned to its owning source on a separate bounce port. Smaller priority numbers win, and 0xFF means "none".

The processor side issues one register operation per cycle through an operation code. It can take the pending interrupt, signal end of interrupt, set the current priority, set the inter-processor request priority, or poll. The combined status word (current priority in bits 31:24, pending identifier in the low bits) and the inter-processor priority are always readable. The block raises a pulse asking all sources to resend when the processor becomes able to take interrupts again. It drives one interrupt line to the processor.

Top module: `irq_pres_ctrl`

## Requirements
- R1: After reset the status word is 0, the inter-processor priority reads 0xFF, the held priority is 0xFF (a take right after reset yields status 0xFF000000) and the line is low.
- R2: With op_code 0, an offer is granted only when its priority is strictly below the current priority and either nothing is held or the held priority is strictly above the offer's priority; otherwise req_accept is 0 and no state changes.
- R3: A granted offer latches its identifier, priority and owner and raises the line; if a source-owned identifier was held, it is driven on the bounce port (rej_valid, rej_id, rej_owner) in that same cycle. The line is high exactly while the identifier field is nonzero.
- R4: Operation take (op_code 1) presents the old status word during its cycle, then loads the status with the held priority on top and a zero identifier, sets the held priority to 0xFF and lowers the line.
- R5: Operation set-priority (op_code 3, value in op_data[7:0]) with a value below the old one, while an identifier is held whose priority is not below the new value, clears the identifier, sets the held priority to 0xFF, lowers the line and bounces a source-owned identifier.
- R6: Set-priority with a value not below the old one and nothing held pulses resend_req; if the inter-processor priority is then below the current priority, the inter-processor check of R7 runs in the same cycle.
- R7: Operation set-IPI (op_code 4, value in op_data[7:0]) with a value below the current priority runs the inter-processor check: if an identifier is held with a priority not above the value, nothing changes; otherwise any held source-owned identifier is bounced, identifier 2 is offered with that priority and the line rises.
- R8: Operation end-of-interrupt (op_code 2) copies op_data[31:24] into the current priority and pulses eoi_valid with eoi_id equal to the low identifier bits of op_data; if nothing is held it also performs the resend of R6.
- R9: Operation poll (op_code 5) changes no state; the inter-processor priority written by set-IPI reads back on mfrr_o.
- R10: Whenever op_code is nonzero, an offer in the same cycle is refused.
- R11: When the inter-processor identifier is displaced, by an offer or by a priority write, nothing is driven on the bounce port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offer from the source layer |
| req_id | input | ID_W | Offered identifier |
| req_prio | input | 8 | Offered priority |
| req_owner | input | OWN_W | Index of the offering source |
| req_accept | output | 1 | Offer granted this cycle |
| op_code | input | 3 | 0 idle, 1 take, 2 end of interrupt, 3 set priority, 4 set IPI, 5 poll |
| op_data | input | 32 | Operation operand |
| xirr_o | output | 32 | Status word: current priority and pending identifier |
| mfrr_o | output | 8 | Inter-processor request priority |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Bounce of a displaced identifier |
| rej_id | output | ID_W | Bounced identifier |
| rej_owner | output | OWN_W | Source that owns the bounced identifier |
| eoi_valid | output | 1 | End-of-interrupt to the source layer |
| eoi_id | output | ID_W | Identifier being completed |
| resend_req | output | 1 | Ask all sources to offer again |

## Verification
Every cycle, the assertions check that the line tracks a nonzero pending identifier, that offers at or above the current priority or during an operation are refused, that a grant shows up in the status next cycle, that take leaves the expected status, and that poll disturbs nothing. Preemption order, bounce contents and owners, the inter-processor check in its three entry paths (set-IPI, set-priority, end of interrupt) and the resend pulses depend on sequences of state. Only the bench's scripted scenarios show them.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_TAKE     = 3'd1,
      OP_EOI      = 3'd2,
      OP_SET_PRIO = 3'd3,
      OP_SET_IPI  = 3'd4,
      OP_POLL     = 3'd5
   } pres_op_e;

   localparam logic [7:0] PRIO_NONE = 8'hFF;
   localparam int         STAT_W    = 32;
endpackage

// File: rtl/irq_pres_arb.sv
// Admission of one offer against the current priority and the held interrupt.
module irq_pres_arb #(
   parameter int ID_W = 24
) (
   input  logic            offer,
   input  logic            busy,
   input  logic [7:0]      offer_prio,
   input  logic [7:0]      cur_prio,
   input  logic [ID_W-1:0] held_id,
   input  logic [7:0]      held_prio,
   input  logic            held_owned,
   output logic            grant,
   output logic            bump
);
   logic held;
   assign held  = (held_id != '0);
   assign grant = offer && !busy && (offer_prio < cur_prio) &&
                  !(held && (held_prio <= offer_prio));
   assign bump  = grant && held && held_owned;
endmodule

// File: rtl/irq_pres_ipi.sv
// Inter-processor check: decides whether the IPI identifier replaces the held one.
module irq_pres_ipi #(
   parameter int ID_W = 24
) (
   input  logic            run,
   input  logic [7:0]      ipi_prio,
   input  logic [ID_W-1:0] held_id,
   input  logic [7:0]      held_prio,
   input  logic            held_owned,
   output logic            take,
   output logic            bump
);
   logic held;
   assign held = (held_id != '0);
   assign take = run && !(held && (held_prio <= ipi_prio));
   assign bump = take && held && held_owned;
endmodule

// File: rtl/irq_pres_ctrl.sv
module irq_pres_ctrl #(
   parameter int ID_W    = 24,
   parameter int OWN_W   = 4,
   parameter int IPI_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [ID_W-1:0]  req_id,
   input  logic [7:0]       req_prio,
   input  logic [OWN_W-1:0] req_owner,
   output logic             req_accept,
   input  logic [2:0]       op_code,
   input  logic [31:0]      op_data,
   output logic [31:0]      xirr_o,
   output logic [7:0]       mfrr_o,
   output logic             irq_o,
   output logic             rej_valid,
   output logic [ID_W-1:0]  rej_id,
   output logic [OWN_W-1:0] rej_owner,
   output logic             eoi_valid,
   output logic [ID_W-1:0]  eoi_id,
   output logic             resend_req
);
   import irq_pres_pkg::*;

   localparam int ID_PAD = irq_pres_pkg::STAT_W - 8 - ID_W;
   localparam logic [ID_W-1:0] IPI_ID = ID_W'(IPI_SRC);

   initial begin
      if (ID_W < 2 || ID_W > 24) $error("ID_W must lie in 2..24");
      if (OWN_W < 1) $error("OWN_W must be at least 1");
      if (IPI_SRC < 1 || IPI_SRC >= (1 << ID_W)) $error("IPI_SRC out of range");
   end

   // state
   logic [7:0]       cppr_q, cppr_n;
   logic [ID_W-1:0]  id_q, id_n;
   logic [7:0]       pend_q, pend_n;
   logic [7:0]       mfrr_q, mfrr_n;
   logic [OWN_W-1:0] own_q, own_n;
   logic             ownv_q, ownv_n;
   logic             irq_q, irq_n;

   pres_op_e op;
   assign op = pres_op_e'(op_code);

   logic busy, grant, arb_bump;
   assign busy = (op != OP_IDLE);

   irq_pres_arb #(.ID_W(ID_W)) u_arb (
      .offer      (req_valid),
      .busy       (busy),
      .offer_prio (req_prio),
      .cur_prio   (cppr_q),
      .held_id    (id_q),
      .held_prio  (pend_q),
      .held_owned (ownv_q),
      .grant      (grant),
      .bump       (arb_bump)
   );

   // decode: which path runs the IPI check, with which priority
   logic       ipi_run, resend;
   logic [7:0] ipi_prio;
   logic       lower_cut;
   always_comb begin
      ipi_run   = 1'b0;
      resend    = 1'b0;
      ipi_prio  = mfrr_q;
      lower_cut = 1'b0;
      case (op)
         OP_SET_IPI: begin
            ipi_prio = op_data[7:0];
            ipi_run  = (op_data[7:0] < cppr_q);
         end
         OP_SET_PRIO: begin
            if (op_data[7:0] < cppr_q)
               lower_cut = (id_q != '0) && (op_data[7:0] <= pend_q);
            else if (id_q == '0) begin
               resend  = 1'b1;
               ipi_run = (mfrr_q < op_data[7:0]);
            end
         end
         OP_EOI: begin
            if (id_q == '0) begin
               resend  = 1'b1;
               ipi_run = (mfrr_q < op_data[31:24]);
            end
         end
         default: ;
      endcase
   end

   logic ipi_take, ipi_bump;
   irq_pres_ipi #(.ID_W(ID_W)) u_ipi (
      .run        (ipi_run),
      .ipi_prio   (ipi_prio),
      .held_id    (id_q),
      .held_prio  (pend_q),
      .held_owned (ownv_q),
      .take       (ipi_take),
      .bump       (ipi_bump)
   );

   // next state and outbound events
   always_comb begin
      cppr_n    = cppr_q;
      id_n      = id_q;
      pend_n    = pend_q;
      mfrr_n    = mfrr_q;
      own_n     = own_q;
      ownv_n    = ownv_q;
      irq_n     = irq_q;
      rej_valid = 1'b0;
      eoi_valid = 1'b0;
      eoi_id    = op_data[ID_W-1:0];
      case (op)
         OP_TAKE: begin
            cppr_n = pend_q;
            id_n   = '0;
            pend_n = PRIO_NONE;
            ownv_n = 1'b0;
            irq_n  = 1'b0;
         end
         OP_EOI: begin
            cppr_n    = op_data[31:24];
            eoi_valid = 1'b1;
         end
         OP_SET_PRIO: begin
            cppr_n = op_data[7:0];
            if (lower_cut) begin
               id_n      = '0;
               pend_n    = PRIO_NONE;
               ownv_n    = 1'b0;
               irq_n     = 1'b0;
               rej_valid = ownv_q;
            end
         end
         OP_SET_IPI: mfrr_n = op_data[7:0];
         OP_IDLE: begin
            if (grant) begin
               id_n      = req_id;
               pend_n    = req_prio;
               own_n     = req_owner;
               ownv_n    = 1'b1;
               irq_n     = 1'b1;
               rej_valid = arb_bump;
            end
         end
         default: ;
      endcase
      if (ipi_take) begin
         id_n      = IPI_ID;
         pend_n    = ipi_prio;
         ownv_n    = 1'b0;
         irq_n     = 1'b1;
         rej_valid = ipi_bump;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cppr_q <= 8'h00;
         id_q   <= '0;
         pend_q <= PRIO_NONE;
         mfrr_q <= PRIO_NONE;
         own_q  <= '0;
         ownv_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         cppr_q <= cppr_n;
         id_q   <= id_n;
         pend_q <= pend_n;
         mfrr_q <= mfrr_n;
         own_q  <= own_n;
         ownv_q <= ownv_n;
         irq_q  <= irq_n;
      end
   end

   generate
      if (ID_PAD > 0) begin : g_pad
         assign xirr_o = {cppr_q, {ID_PAD{1'b0}}, id_q};
      end else begin : g_full
         assign xirr_o = {cppr_q, id_q};
      end
   endgenerate

   assign mfrr_o     = mfrr_q;
   assign irq_o      = irq_q;
   assign req_accept = grant;
   assign rej_id     = id_q;
   assign rej_owner  = own_q;
   assign resend_req = resend;
endmodule

// File: rtl/irq_pres_ctrl_chk.sv
module irq_pres_ctrl_chk #(
   parameter int ID_W = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      op_code,
   input logic            req_valid,
   input logic [ID_W-1:0] req_id,
   input logic [7:0]      req_prio,
   input logic            req_accept,
   input logic [31:0]     xirr_o,
   input logic [7:0]      mfrr_o,
   input logic            irq_o,
   input logic [7:0]      pend_q
);
   p_line_tracks_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (xirr_o[ID_W-1:0] != '0));

   p_low_offer_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op_code == 3'd0 && req_prio >= xirr_o[31:24]) |-> !req_accept);

   p_grant_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |=> (irq_o && xirr_o[ID_W-1:0] == $past(req_id)));

   p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'd1) |=> (!irq_o && xirr_o[ID_W-1:0] == '0 &&
                             xirr_o[31:24] == $past(pend_q)));

   p_poll_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'd5) |=> ($stable(xirr_o) && $stable(mfrr_o)));

   p_op_blocks_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code != 3'd0) |-> !req_accept);
endmodule

bind irq_pres_ctrl irq_pres_ctrl_chk #(.ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_code    (op_code),
   .req_valid  (req_valid),
   .req_id     (req_id),
   .req_prio   (req_prio),
   .req_accept (req_accept),
   .xirr_o     (xirr_o),
   .mfrr_o     (mfrr_o),
   .irq_o      (irq_o),
   .pend_q     (pend_q)
);

// File: tb/irq_pres_ctrl_test.sv
module irq_pres_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_id = '0;
   logic [7:0]  req_prio = '0;
   logic [3:0]  req_owner = '0;
   logic        req_accept;
   logic [2:0]  op_code = '0;
   logic [31:0] op_data = '0;
   logic [31:0] xirr_o;
   logic [7:0]  mfrr_o;
   logic        irq_o;
   logic        rej_valid;
   logic [23:0] rej_id;
   logic [3:0]  rej_owner;
   logic        eoi_valid;
   logic [23:0] eoi_id;
   logic        resend_req;

   irq_pres_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_prio(req_prio), .req_owner(req_owner), .req_accept(req_accept),
      .op_code(op_code), .op_data(op_data), .xirr_o(xirr_o), .mfrr_o(mfrr_o),
      .irq_o(irq_o), .rej_valid(rej_valid), .rej_id(rej_id),
      .rej_owner(rej_owner), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .resend_req(resend_req)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] data;
      logic        rv;
      logic [23:0] rid;
      logic [7:0]  rpri;
      logic [3:0]  rown;
      logic        e_acc;
      logic        e_rej;
      logic [23:0] e_rid;
      logic [3:0]  e_rown;
      logic        e_eoi;
      logic        e_res;
      logic [31:0] e_xirr;
      logic        e_irq;
   } step_t;

   localparam int N = 19;
   // walked from reset; each row is one cycle
   localparam step_t TBL [N] = '{
      '{3'd5, 32'h0,        1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'h00000000, 1'b0}, // poll
      '{3'd0, 32'h0,        1'b1, 24'h10, 8'h05, 4'h1, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'h00000000, 1'b0}, // R2 refused, cppr 0
      '{3'd3, 32'hFF,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b1, 32'hFF000000, 1'b0}, // R6 raise cppr
      '{3'd0, 32'h0,        1'b1, 24'h10, 8'h05, 4'h1, 1'b1, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000010, 1'b1}, // R3 grant
      '{3'd0, 32'h0,        1'b1, 24'h20, 8'h05, 4'h2, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000010, 1'b1}, // R2 equal prio
      '{3'd0, 32'h0,        1'b1, 24'h20, 8'h03, 4'h2, 1'b1, 1'b1, 24'h10, 4'h1, 1'b0, 1'b0, 32'hFF000020, 1'b1}, // R3 preempt
      '{3'd4, 32'h04,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000020, 1'b1}, // R7 no change
      '{3'd4, 32'h01,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b1, 24'h20, 4'h2, 1'b0, 1'b0, 32'hFF000002, 1'b1}, // R7 IPI wins
      '{3'd0, 32'h0,        1'b1, 24'h30, 8'h02, 4'h3, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000002, 1'b1}, // R2 vs IPI
      '{3'd1, 32'h0,        1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'h01000000, 1'b0}, // R4 take
      '{3'd0, 32'h0,        1'b1, 24'h40, 8'h00, 4'h1, 1'b1, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'h01000040, 1'b1}, // R3 grant
      '{3'd3, 32'h00,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b1, 24'h40, 4'h1, 1'b0, 1'b0, 32'h00000000, 1'b0}, // R5 cut
      '{3'd2, 32'hFF000002, 1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b1, 1'b1, 32'hFF000002, 1'b1}, // R8 eoi, IPI re-offered
      '{3'd3, 32'hFF,       1'b1, 24'h50, 8'h00, 4'h1, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000002, 1'b1}, // R10 op wins
      '{3'd4, 32'hFF,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000002, 1'b1}, // R7 not below
      '{3'd1, 32'h0,        1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'h01000000, 1'b0}, // R4 take
      '{3'd2, 32'hFF000002, 1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b1, 1'b1, 32'hFF000000, 1'b0}, // R8 eoi, no IPI
      '{3'd4, 32'h03,       1'b0, 24'h00, 8'h00, 4'h0, 1'b0, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000002, 1'b1}, // R7 IPI
      '{3'd0, 32'h0,        1'b1, 24'h60, 8'h01, 4'h5, 1'b1, 1'b0, 24'h00, 4'h0, 1'b0, 1'b0, 32'hFF000060, 1'b1}  // R11 IPI displaced
   };

   logic        s_acc, s_rej, s_eoi, s_res;
   logic [23:0] s_rid, s_eid;
   logic [3:0]  s_rown;
   logic [31:0] s_xirr;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; samples combinational outputs mid-cycle
   task automatic step(input logic [2:0] op, input logic [31:0] d, input logic rv,
                       input logic [23:0] id, input logic [7:0] pr, input logic [3:0] ow);
      op_code = op; op_data = d; req_valid = rv; req_id = id; req_prio = pr; req_owner = ow;
      #2;
      s_acc = req_accept; s_rej = rej_valid; s_rid = rej_id; s_rown = rej_owner;
      s_eoi = eoi_valid; s_eid = eoi_id; s_res = resend_req; s_xirr = xirr_o;
      @(negedge clk);
      op_code = 3'd0; req_valid = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 status", xirr_o, 32'h0);
      chk("R1 ipi prio", {24'h0, mfrr_o}, 32'hFF);
      chk("R1 line", {31'h0, irq_o}, 32'h0);

      for (int i = 0; i < N; i++) begin
         step(TBL[i].op, TBL[i].data, TBL[i].rv, TBL[i].rid, TBL[i].rpri, TBL[i].rown);
         chk($sformatf("R2 grant row %0d", i), {31'h0, s_acc}, {31'h0, TBL[i].e_acc});
         chk($sformatf("R3 bounce row %0d", i), {31'h0, s_rej}, {31'h0, TBL[i].e_rej});
         if (TBL[i].e_rej) begin
            chk($sformatf("R3 bounce id row %0d", i), {8'h0, s_rid}, {8'h0, TBL[i].e_rid});
            chk($sformatf("R3 bounce owner row %0d", i), {28'h0, s_rown}, {28'h0, TBL[i].e_rown});
         end
         chk($sformatf("R8 eoi row %0d", i), {31'h0, s_eoi}, {31'h0, TBL[i].e_eoi});
         if (TBL[i].e_eoi)
            chk($sformatf("R8 eoi id row %0d", i), {8'h0, s_eid}, {8'h0, TBL[i].data[23:0]});
         chk($sformatf("R6 resend row %0d", i), {31'h0, s_res}, {31'h0, TBL[i].e_res});
         chk($sformatf("R7 status row %0d", i), xirr_o, TBL[i].e_xirr);
         chk($sformatf("R3 line row %0d", i), {31'h0, irq_o}, {31'h0, TBL[i].e_irq});
      end

      // R9 set-IPI value visible, poll leaves everything alone
      chk("R9 ipi prio readback", {24'h0, mfrr_o}, 32'h03);
      step(3'd5, 32'hFFFFFFFF, 1'b0, 24'h0, 8'h0, 4'h0);
      chk("R9 poll status", xirr_o, 32'hFF000060);
      chk("R9 poll ipi prio", {24'h0, mfrr_o}, 32'h03);
      chk("R9 poll line", {31'h0, irq_o}, 32'h1);

      // R4 take returns the old status during its cycle
      step(3'd1, 32'h0, 1'b0, 24'h0, 8'h0, 4'h0);
      chk("R4 returned status", s_xirr, 32'hFF000060);
      chk("R4 new status", xirr_o, 32'h01000000);
      chk("R4 line low", {31'h0, irq_o}, 32'h0);

      // R1 held priority is 0xFF after reset: a take yields 0xFF000000
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 status after reset", xirr_o, 32'h0);
      chk("R1 ipi prio after reset", {24'h0, mfrr_o}, 32'hFF);
      step(3'd1, 32'h0, 1'b0, 24'h0, 8'h0, 4'h0);
      chk("R1 held prio via take", xirr_o, 32'hFF000000);

      summary();
   end
endmodule